// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with Split Parking

This block decides which of several bus initiators owns a pipelined shared bus. Each initiator raises its request line. The arbiter then grants the bus to the highest-priority candidate and reports the owner as a binary index. Index 0 has the highest priority. The grant and the index change only on a clock edge where the bus ready signal is high. This keeps ownership aligned with address phases.

A target may be unable to finish a transfer soon. In that case it answers with a two-cycle split response: one cycle with ready low, then one cycle with ready high. The arbiter then parks the initiator whose data phase received the split. The initiator stays parked in a per-initiator park register, and the arbiter hands the bus to another candidate. Targets wake parked initiators through a release vector that is OR-combined across targets and sampled on every cycle. A woken initiator competes again only through normal priority.

When no unparked initiator is requesting, the bus goes to a parameterised fallback initiator. That initiator issues idle transfers.

Top module: `prio_split_arbiter`

## Requirements
- R1: After reset, exactly one bit of `grantVec` is high at all times, and it is the bit whose index equals `ownerId`.
- R2: During and right after reset, no initiator is parked and the bus is granted to the fallback initiator `FALLBACK_ID` (default 7 with 8 initiators).
- R3: On an edge where the arbiter advances, the new owner is the lowest-indexed initiator that is requesting and not parked. Index 0 has the highest priority.
- R4: On an edge where `busReady` is low, `grantVec` and `ownerId` keep their values whatever the requests are.
- R5: A split response parks the data-phase initiator. The data-phase initiator is the owner before the most recent ready-high edge. A split is recognised in a cycle with `busReady` high and `respCode` = 2'b11, provided the previous cycle had `respCode` = 2'b11 with `busReady` low. That initiator is already excluded from the arbitration on the same edge, and it stays excluded until it is released.
- R6: A high bit i of `splitWake` in a cycle un-parks initiator i at that edge. Initiator i may win the arbitration on that same edge.
- R7: If initiator i is being parked and woken in the same cycle, the park wins and i stays parked.
- R8: If no initiator is both requesting and unparked, the fallback initiator is granted. This includes the case where every requester is parked.
- R9: A woken initiator gets the bus only when no higher-priority unparked initiator is requesting.
- R10: No initiator is parked by `respCode` 2'b00 (okay), 2'b01 (error) or 2'b10 (retry). A single ready-high split cycle with no ready-low split cycle before it parks nothing, and neither does a ready-low split cycle followed by a non-split code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_INIT | Bus request, one bit per initiator |
| busReady | input | 1 | Transfer-complete indication of the bus |
| respCode | input | 2 | Response of the current data phase (00 okay, 01 error, 10 retry, 11 split) |
| splitWake | input | NUM_INIT | OR of all targets' wake vectors, one bit per initiator |
| grantVec | output | NUM_INIT | One-hot grant |
| ownerId | output | $clog2(NUM_INIT) | Index of the granted initiator |

## Verification
The checks assume that targets follow the two-cycle split sequence. They also assume that `respCode` describes the initiator of the current data phase, and that requests and wake bits are stable across the clock edge. The stimulus is driven only on falling edges, so every input is settled well before the rising edge that samples it. The directed stimulus always sends split responses in the proper wait-then-complete form, except in the R10 cases, which break that form on purpose to show that no initiator gets parked. A following random phase drives arbitrary codes. This is acceptable because the ready-low split cycle required by R5 is enforced inside the block, so arbitrary codes cannot park an initiator by accident.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY  = 2'b00,
    RESP_ERROR = 2'b01,
    RESP_RETRY = 2'b10,
    RESP_SPLIT = 2'b11
  } respCode_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic advance;   // ownership may move on this edge
    logic parkHit;   // completing cycle of a split response
  } arbStrobes_t;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_INIT = 8,
  localparam int IDW = $clog2(NUM_INIT)
) (
  input  logic [NUM_INIT-1:0] cand,
  output logic                found,
  output logic [IDW-1:0]      winIdx
);

  // Scan from the lowest priority upward so that index 0 wins last.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = NUM_INIT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found  = 1'b1;
        winIdx = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import prio_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReady,
  input  logic [1:0]  respCode,
  output arbStrobes_t stb
);

  logic splitWaitQ;

  always_ff @(posedge clk) begin
    if (!rstN) splitWaitQ <= 1'b0;
    else       splitWaitQ <= !busReady && (respCode == RESP_SPLIT);
  end

  always_comb begin
    stb.advance = busReady;
    stb.parkHit = busReady && (respCode == RESP_SPLIT) && splitWaitQ;
  end

  // R5: a park strobe only follows a stalled split cycle
  p_park_after_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.parkHit |-> $past(!busReady && respCode == RESP_SPLIT));

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import prio_arb_pkg::*;
#(
  parameter int NUM_INIT    = 8,
  parameter int FALLBACK_ID = 7,
  localparam int IDW = $clog2(NUM_INIT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INIT-1:0] reqVec,
  input  logic [NUM_INIT-1:0] splitWake,
  input  arbStrobes_t         stb,
  output logic [NUM_INIT-1:0] grantVec,
  output logic [IDW-1:0]      ownerId
);

  localparam logic [IDW-1:0] FALLBACK = IDW'(FALLBACK_ID);

  logic [NUM_INIT-1:0] parkQ, parkD, parkSet, cand, grantQ;
  logic [IDW-1:0]      ownerQ, dataOwnerQ, winIdx, nextOwner;
  logic                found;

  assign parkSet = stb.parkHit ? (NUM_INIT'(1) << dataOwnerQ) : '0;

  // Per-initiator park bit: a new park beats a wake in the same cycle
  for (genvar i = 0; i < NUM_INIT; i++) begin : g_park
    assign parkD[i] = parkSet[i] | (parkQ[i] & ~splitWake[i]);

    p_wake_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
      (splitWake[i] && !parkSet[i]) |=> !parkQ[i]);
  end

  assign cand = reqVec & ~parkD;

  prio_pick #(.NUM_INIT(NUM_INIT)) pick_i (
    .cand   (cand),
    .found  (found),
    .winIdx (winIdx)
  );

  assign nextOwner = found ? winIdx : FALLBACK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parkQ      <= '0;
      ownerQ     <= FALLBACK;
      dataOwnerQ <= FALLBACK;
      grantQ     <= NUM_INIT'(1) << FALLBACK;
    end else begin
      parkQ <= parkD;
      if (stb.advance) begin
        ownerQ     <= nextOwner;
        dataOwnerQ <= ownerQ;
        grantQ     <= NUM_INIT'(1) << nextOwner;
      end
    end
  end

  assign grantVec = grantQ;
  assign ownerId  = ownerQ;

  p_single_owner_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(grantQ) == 1) && grantQ[ownerQ]);

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(ownerQ) && $stable(grantQ));

  p_split_parks_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.parkHit |=> parkQ[$past(dataOwnerQ)]);

  p_idle_fallback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && (cand == '0)) |=> ownerQ == FALLBACK);

endmodule

// File: rtl/prio_split_arbiter.sv
module prio_split_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_INIT    = 8,
  parameter int FALLBACK_ID = 7,
  localparam int IDW = $clog2(NUM_INIT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INIT-1:0] reqVec,
  input  logic                busReady,
  input  logic [1:0]          respCode,
  input  logic [NUM_INIT-1:0] splitWake,
  output logic [NUM_INIT-1:0] grantVec,
  output logic [IDW-1:0]      ownerId
);

  arbStrobes_t stb;

  arb_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busReady (busReady),
    .respCode (respCode),
    .stb      (stb)
  );

  arb_datapath #(
    .NUM_INIT    (NUM_INIT),
    .FALLBACK_ID (FALLBACK_ID)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .splitWake (splitWake),
    .stb       (stb),
    .grantVec  (grantVec),
    .ownerId   (ownerId)
  );

endmodule

// File: tb/prio_split_arbiter_tb.sv
module prio_split_arbiter_tb_top;

  localparam int N   = 8;
  localparam int FB  = 7;
  localparam int IDW = $clog2(N);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   reqVec = '0;
  logic           busReady = 1'b0;
  logic [1:0]     respCode = 2'b00;
  logic [N-1:0]   splitWake = '0;
  logic [N-1:0]   grantVec;
  logic [IDW-1:0] ownerId;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    owner;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state, kept from the requirements alone
  logic [N-1:0] mPark = '0;
  int           mOwner = FB;
  int           mDataOwner = FB;
  logic         mWait = 1'b0;

  always #5 clk = ~clk;

  prio_split_arbiter #(.NUM_INIT(N), .FALLBACK_ID(FB)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .busReady  (busReady),
    .respCode  (respCode),
    .splitWake (splitWake),
    .grantVec  (grantVec),
    .ownerId   (ownerId)
  );

  function automatic int pickWinner(logic [N-1:0] req, logic [N-1:0] park);
    for (int i = 0; i < N; i++)
      if (req[i] && !park[i]) return i;
    return FB;
  endfunction

  task automatic checkOwner(int expOwner, string tag);
    logic [N-1:0] expGrant;
    expGrant = N'(1) << expOwner;
    checks++;
    if (int'(ownerId) != expOwner || grantVec !== expGrant) begin
      errors++;
      $display("FAIL %s: owner=%0d grant=%b expected owner=%0d grant=%b",
               tag, ownerId, grantVec, expOwner, expGrant);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result
  task automatic step(logic [N-1:0] req, logic rdy, logic [1:0] rc,
                      logic [N-1:0] wake, string tag);
    logic [N-1:0] setV, parkNext;
    expItem_t it;
    @(negedge clk);
    reqVec = req; busReady = rdy; respCode = rc; splitWake = wake;
    setV = (rdy && rc == 2'b11 && mWait) ? (N'(1) << mDataOwner) : '0;
    parkNext = setV | (mPark & ~wake);
    if (rdy) begin
      mDataOwner = mOwner;
      mOwner = pickWinner(req, parkNext);
    end
    mPark = parkNext;
    mWait = !rdy && rc == 2'b11;
    it.owner = mOwner;
    it.tag = tag;
    @(posedge clk);
    expQ.push_back(it);
  endtask

  // Monitor: compare at the falling edge after each update
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checkOwner(it.owner, it.tag);
    end
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOwner(FB, "R2 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOwner(FB, "R2 after reset");

    step(8'h00, 1, 2'b00, 8'h00, "R8 idle");
    step(8'h06, 1, 2'b00, 8'h00, "R3 pick 1");
    step(8'h0C, 1, 2'b00, 8'h00, "R3 pick 2");
    step(8'h80, 1, 2'b00, 8'h00, "R3 only fallback requests");
    step(8'h01, 0, 2'b00, 8'h00, "R4 stall");
    step(8'h01, 0, 2'b00, 8'h00, "R4 stall again");
    step(8'h01, 1, 2'b00, 8'h00, "R3 pick 0");

    // park initiator 2
    step(8'h04, 1, 2'b00, 8'h00, "R3 pick 2");
    step(8'h0C, 1, 2'b00, 8'h00, "R3 keep 2");
    step(8'h0C, 0, 2'b11, 8'h00, "R4 split wait");
    step(8'h0C, 1, 2'b11, 8'h00, "R5 park 2 same edge");
    step(8'h0C, 1, 2'b00, 8'h00, "R5 stays parked");
    step(8'h04, 1, 2'b00, 8'h00, "R8 all parked");
    step(8'h0C, 1, 2'b00, 8'h04, "R6 wake wins same edge");

    // park initiator 4, then wake it under competition
    step(8'h10, 1, 2'b00, 8'h00, "R3 pick 4");
    step(8'h10, 1, 2'b00, 8'h00, "R3 keep 4");
    step(8'h10, 0, 2'b11, 8'h00, "R4 split wait");
    step(8'h10, 1, 2'b11, 8'h00, "R5 park 4");
    step(8'h12, 1, 2'b00, 8'h00, "R3 pick 1");
    step(8'h12, 1, 2'b00, 8'h10, "R9 woken loses to 1");
    step(8'h10, 1, 2'b00, 8'h00, "R9 woken regains");

    // codes that must not park
    step(8'h10, 1, 2'b01, 8'h00, "R10 error");
    step(8'h10, 1, 2'b10, 8'h00, "R10 retry");
    step(8'h10, 1, 2'b11, 8'h00, "R10 split without wait");
    step(8'h10, 0, 2'b11, 8'h00, "R4 split wait");
    step(8'h10, 1, 2'b00, 8'h00, "R10 wait then okay");
    step(8'h10, 1, 2'b00, 8'h00, "R10 still granted");

    // park and wake together
    step(8'h10, 0, 2'b11, 8'h00, "R4 split wait");
    step(8'h10, 1, 2'b11, 8'h10, "R7 park beats wake");
    step(8'h10, 1, 2'b00, 8'h00, "R7 still parked");
    step(8'h10, 1, 2'b00, 8'h10, "R6 wake later");

    for (int k = 0; k < 300; k++) begin
      step(N'($urandom), 1'($urandom), 2'($urandom),
           (($urandom % 4) == 0) ? N'($urandom) : '0, "R1 random");
    end

    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule